// File: doc/BRIEF.md
# Clock-Synchronous Serial Transmitter with Clear-to-Send Gating

This block is the transmit side of a clock-synchronous serial port. Software places a byte in a one-entry holding buffer. When the shift register is free, the byte moves into it, and the block shifts it out least significant bit first on a data output. Alongside the data it drives a transfer clock that it generates itself. The clock rate comes from a programmable half-period divider. That divider counts pulses of a count-source enable input, so the transfer clock runs from a prescaled tick rather than from the system clock directly.

The transfer clock only toggles while a frame is being shifted. Between frames it rests high. A new frame is started only at a frame boundary, and only when the clear-to-send input is low and transmit enable is set. A frame that has already begun always runs to its eighth bit. If a refill byte is already waiting when a frame ends, the next frame follows with no idle clock period.

Two status flags report an empty holding buffer and a fully drained transmitter. An interrupt request flag can be set either by each buffer-to-shifter transfer or by each completed frame. It is cleared by an acknowledge input.

Top module: `sst_sync_tx`

## Requirements
- R1: Inside a frame, every high and every low phase of `sclk_o` lasts exactly n+1 count-source enables, where n is the divider value. This gives a transfer clock period of 2(n+1) enables.
- R2: A frame carries 8 data bits, bit 0 first. A receiver that samples `sdo_o` on each rising edge of `sclk_o` recovers the written byte.
- R3: `sclk_o` is high whenever no frame is active. `sdo_o` changes only on falling edges of `sclk_o`.
- R4: A byte written while the shifter is idle and sending is allowed is taken into the shifter on the next cycle, and `buf_empty_o` returns to 1.
- R5: While `cts_i` is 1, no new frame starts and `sclk_o` stays high. Once `cts_i` returns to 0, the pending byte is sent.
- R6: While `tx_en_i` is 0, no new frame starts, even with `cts_i` low.
- R7: `cts_i` and `tx_en_i` are only sampled at frame boundaries. A frame already started completes all 8 bits after either of them blocks.
- R8: If the buffer is refilled before a frame ends and sending is allowed, the next frame's first falling edge comes n+1 enables after the previous frame's last rising edge.
- R9: With `irq_on_done_i` = 0, `irq_o` is set on each buffer-to-shifter transfer. `irq_ack_i` clears it, and a new set wins over a simultaneous acknowledge.
- R10: With `irq_on_done_i` = 1, `irq_o` is set when a frame's eighth bit completes. It is not set by the transfer into the shifter.
- R11: `shift_empty_o` is 0 while a frame is shifting or while the buffer holds a byte, and 1 only when both are empty.
- R12: A divider value written between frames sets the clock period of the frames that follow.
- R13: After reset, `sclk_o`=1, `sdo_o`=1, `buf_empty_o`=1, `shift_empty_o`=1 and `irq_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en_i | input | 1 | Count-source enable pulse for the divider |
| div_wr_i | input | 1 | Write strobe for the divider value |
| div_val_i | input | 8 | Divider value n |
| tx_en_i | input | 1 | Transmit enable; 0 blocks new frames |
| cts_i | input | 1 | Clear-to-send; 1 holds off new frames |
| buf_wr_i | input | 1 | Write strobe for the holding buffer |
| buf_data_i | input | 8 | Byte to transmit |
| irq_on_done_i | input | 1 | Interrupt source: 0 buffer transfer, 1 frame complete |
| irq_ack_i | input | 1 | Clears the interrupt request flag |
| sclk_o | output | 1 | Transfer clock, idles high |
| sdo_o | output | 1 | Serial data out, LSB first |
| buf_empty_o | output | 1 | Holding buffer is empty |
| shift_empty_o | output | 1 | Shifter and buffer are both empty |
| irq_o | output | 1 | Interrupt request flag |

## Verification
On every cycle, the assertions check the following:
- the clock rests high outside frames;
- data moves only on falling edges;
- no frame starts unless clear-to-send and enable allowed it;
- started frames are never cut short;
- the divider count stays within range;
- the interrupt flag responds to its set source and its acknowledge.

Other behaviour only shows up across whole scenarios in the bench:
- the bit order and the recovered bytes;
- the exact phase lengths in enables;
- the back-to-back gap;
- a held-off byte finally leaving once the gate opens;
- a new divider value changing the period of later frames.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic {
    IRQ_ON_LOAD = 1'b0,
    IRQ_ON_DONE = 1'b1
  } sst_irq_src_e;
endpackage

// File: rtl/sst_baud_div.sv
module sst_baud_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en_i,
  input  logic             run_i,
  input  logic             wr_i,
  input  logic [DIV_W-1:0] val_i,
  output logic             half_tick_o
);
  logic [DIV_W-1:0] n_q, n_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             hit;

  assign hit         = (cnt_q == n_q);
  assign half_tick_o = run_i & cnt_en_i & ~wr_i & hit;

  always_comb begin
    n_d   = n_q;
    cnt_d = cnt_q;
    if (wr_i) begin
      n_d   = val_i;
      cnt_d = '0;
    end else if (!run_i) begin
      cnt_d = '0;
    end else if (cnt_en_i) begin
      cnt_d = hit ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q   <= '0;
      cnt_q <= '0;
    end else begin
      n_q   <= n_d;
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= n_q)); // R1
endmodule

// File: rtl/sst_txbuf.sv
module sst_txbuf #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [BITS-1:0] data_i,
  input  logic            take_i,
  output logic            full_o,
  output logic [BITS-1:0] data_o
);
  logic            full_q, full_d;
  logic [BITS-1:0] data_q, data_d;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    if (take_i) full_d = 1'b0;
    if (wr_i) begin
      full_d = 1'b1;
      data_d = data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  AST_BUF_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !wr_i) |=> !full_q); // R4
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter #(
  parameter int BITS      = 8,
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            half_tick_i,
  input  logic            can_start_i,
  input  logic [BITS-1:0] load_data_i,
  output logic            take_o,
  output logic            frame_done_o,
  output logic            active_o,
  output logic            sclk_o,
  output logic            sdo_o
);
  localparam int CW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic            active_q, active_d;
  logic            sclk_q, sclk_d;
  logic            sdo_q, sdo_d;
  logic [BITS-1:0] sh_q, sh_d, sh_next;
  logic [CW-1:0]   bit_q, bit_d;
  logic            out_bit;
  logic            boundary;

  generate
    if (LSB_FIRST) begin : g_lsb
      assign out_bit = sh_q[0];
      assign sh_next = {1'b0, sh_q[BITS-1:1]};
    end else begin : g_msb
      assign out_bit = sh_q[BITS-1];
      assign sh_next = {sh_q[BITS-2:0], 1'b0};
    end
  endgenerate

  assign frame_done_o = active_q & half_tick_i & ~sclk_q & (bit_q == LAST);
  assign boundary     = ~active_q | frame_done_o;
  assign take_o       = boundary & can_start_i;

  always_comb begin
    active_d = active_q;
    sclk_d   = sclk_q;
    sdo_d    = sdo_q;
    sh_d     = sh_q;
    bit_d    = bit_q;
    if (take_o) begin
      active_d = 1'b1;
      sh_d     = load_data_i;
      bit_d    = '0;
      sclk_d   = 1'b1;
    end else if (frame_done_o) begin
      active_d = 1'b0;
      sclk_d   = 1'b1;
    end else if (active_q && half_tick_i) begin
      if (sclk_q) begin
        sclk_d = 1'b0;
        sdo_d  = out_bit;
        sh_d   = sh_next;
      end else begin
        sclk_d = 1'b1;
        bit_d  = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b1;
      sdo_q    <= 1'b1;
      sh_q     <= '0;
      bit_q    <= '0;
    end else begin
      active_q <= active_d;
      sclk_q   <= sclk_d;
      sdo_q    <= sdo_d;
      sh_q     <= sh_d;
      bit_q    <= bit_d;
    end
  end

  assign active_o = active_q;
  assign sclk_o   = sclk_q;
  assign sdo_o    = sdo_q;

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> sclk_q); // R3
  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(sclk_q) |-> $stable(sdo_q)); // R3
  AST_FRAME_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !frame_done_o) |=> active_q); // R7
endmodule

// File: rtl/sst_irq.sv
module sst_irq
  import sst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic on_done_i,
  input  logic load_i,
  input  logic done_i,
  input  logic ack_i,
  output logic irq_o
);
  sst_irq_src_e src;
  logic         set;
  logic         irq_q, irq_d;

  assign src = sst_irq_src_e'(on_done_i);

  always_comb begin
    unique case (src)
      IRQ_ON_DONE: set = done_i;
      default:     set = load_i;
    endcase
    irq_d = set | (irq_q & ~ack_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  AST_IRQ_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_done_i && load_i) |=> irq_q); // R9
  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (on_done_i && done_i) |=> irq_q); // R10
  AST_IRQ_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !load_i && !done_i) |=> !irq_q); // R9
endmodule

// File: rtl/sst_sync_tx.sv
module sst_sync_tx
  import sst_pkg::*;
#(
  parameter int BITS      = 8,
  parameter int DIV_W     = 8,
  parameter bit LSB_FIRST = 1'b1,
  parameter int SYNC_STG  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en_i,
  input  logic             div_wr_i,
  input  logic [DIV_W-1:0] div_val_i,
  input  logic             tx_en_i,
  input  logic             cts_i,
  input  logic             buf_wr_i,
  input  logic [BITS-1:0]  buf_data_i,
  input  logic             irq_on_done_i,
  input  logic             irq_ack_i,
  output logic             sclk_o,
  output logic             sdo_o,
  output logic             buf_empty_o,
  output logic             shift_empty_o,
  output logic             irq_o
);
  logic [SYNC_STG-1:0] rst_sync_q;
  logic                rst_int_n;
  logic                half_tick, take, frame_done, active;
  logic                buf_full, can_start;
  logic [BITS-1:0]     buf_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STG-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STG-1];

  assign can_start = buf_full & tx_en_i & ~cts_i;

  sst_baud_div #(.DIV_W(DIV_W)) u_div (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cnt_en_i    (cnt_en_i),
    .run_i       (active),
    .wr_i        (div_wr_i),
    .val_i       (div_val_i),
    .half_tick_o (half_tick)
  );

  sst_txbuf #(.BITS(BITS)) u_buf (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_i   (buf_wr_i),
    .data_i (buf_data_i),
    .take_i (take),
    .full_o (buf_full),
    .data_o (buf_data)
  );

  sst_shifter #(.BITS(BITS), .LSB_FIRST(LSB_FIRST)) u_shf (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .half_tick_i  (half_tick),
    .can_start_i  (can_start),
    .load_data_i  (buf_data),
    .take_o       (take),
    .frame_done_o (frame_done),
    .active_o     (active),
    .sclk_o       (sclk_o),
    .sdo_o        (sdo_o)
  );

  sst_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .on_done_i (irq_on_done_i),
    .load_i    (take),
    .done_i    (frame_done),
    .ack_i     (irq_ack_i),
    .irq_o     (irq_o)
  );

  assign buf_empty_o   = ~buf_full;
  assign shift_empty_o = ~active & ~buf_full;

  AST_START_NEEDS_CTS: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(active) |-> $past(!cts_i)); // R5
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(active) |-> $past(tx_en_i)); // R6
  AST_DRAINED_CLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_int_n)
    shift_empty_o |-> sclk_o); // R11
endmodule

// File: tb/sst_sync_tx_tb.sv
module sst_sync_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en_i = 1'b1, div_wr_i = 1'b0, tx_en_i = 1'b1, cts_i = 1'b0;
  logic       buf_wr_i = 1'b0, irq_on_done_i = 1'b0, irq_ack_i = 1'b0;
  logic [7:0] div_val_i = 8'd0, buf_data_i = 8'd0;
  logic       sclk_o, sdo_o, buf_empty_o, shift_empty_o, irq_o;

  int checks = 0, fails = 0, cyc = 0;
  int cur_n = 0;
  bit rand_en = 1'b0;
  logic [7:0] sent [0:255];
  logic [7:0] rx [0:255];
  int sent_n = 0, rx_n = 0;
  logic       prev_sclk, prev_sdo;
  int         ens, rx_bits, gap_ens;
  logic [7:0] rx_sh;

  always #2.5 clk = ~clk;

  sst_sync_tx u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en_i), .div_wr_i(div_wr_i),
    .div_val_i(div_val_i), .tx_en_i(tx_en_i), .cts_i(cts_i), .buf_wr_i(buf_wr_i),
    .buf_data_i(buf_data_i), .irq_on_done_i(irq_on_done_i), .irq_ack_i(irq_ack_i),
    .sclk_o(sclk_o), .sdo_o(sdo_o), .buf_empty_o(buf_empty_o),
    .shift_empty_o(shift_empty_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int half_len(input int n);
    return n + 1;
  endfunction

  // receiver model: samples on rising edges, times phases in enables
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_sclk = 1'b1; prev_sdo = 1'b1; ens = 0; rx_bits = 0; rx_sh = 8'h00;
    end else begin
      if (sdo_o !== prev_sdo && !(prev_sclk == 1'b1 && sclk_o == 1'b0))
        chk(1'b0, "R3 sdo moved off a falling edge", sdo_o, prev_sdo);
      if (sclk_o !== prev_sclk) begin
        if (sclk_o == 1'b0) begin
          if (rx_bits == 0) gap_ens = ens;
          else chk(ens == half_len(cur_n), "R1 low-going phase", ens, half_len(cur_n));
        end else begin
          chk(ens == half_len(cur_n), "R1 high-going phase", ens, half_len(cur_n));
          rx_sh = {sdo_o, rx_sh[7:1]};
          rx_bits++;
          if (rx_bits == 8) begin
            rx[rx_n[7:0]] = rx_sh;
            rx_n++;
            rx_bits = 0;
          end
        end
        ens = 0;
      end
      ens += int'(cnt_en_i);
      prev_sclk = sclk_o;
      prev_sdo  = sdo_o;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    cnt_en_i = rand_en ? 1'($urandom % 2) : 1'b1;
  endtask

  task automatic write_byte(input logic [7:0] b);
    buf_wr_i = 1'b1; buf_data_i = b;
    sent[sent_n[7:0]] = b; sent_n++;
    tick();
    buf_wr_i = 1'b0;
  endtask

  task automatic set_div(input int n);
    div_wr_i = 1'b1; div_val_i = 8'(n);
    tick();
    div_wr_i = 1'b0;
    cur_n = n;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 20000 && !shift_empty_o; k++) tick();
    tick();
  endtask

  task automatic wait_rx(input int target);
    for (int k = 0; k < 20000 && rx_n < target; k++) tick();
  endtask

  task automatic ack();
    irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int hi_cnt, n0, w;
    void'($urandom(32'd4242));
    gap_ens = -1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) tick();
    // R13 reset state
    chk(sclk_o == 1'b1 && sdo_o == 1'b1, "R13 line idle", {sclk_o, sdo_o}, 3);
    chk(buf_empty_o && shift_empty_o, "R13 flags", {buf_empty_o, shift_empty_o}, 3);
    chk(irq_o == 1'b0, "R13 irq", irq_o, 0);

    // R4 R11 R2: single byte at n=0
    write_byte(8'hA5);
    chk(buf_empty_o == 1'b0, "R4 buffer full after write", buf_empty_o, 0);
    tick();
    chk(buf_empty_o == 1'b1, "R4 buffer refilled flag", buf_empty_o, 1);
    chk(shift_empty_o == 1'b0, "R11 shifting", shift_empty_o, 0);
    wait_done();
    chk(rx_n == 1 && rx[0] == 8'hA5, "R2 byte A5 LSB first", rx[0], 8'hA5);

    // R5: clear-to-send high holds the frame
    cts_i = 1'b1;
    write_byte(8'h3C);
    hi_cnt = 0;
    repeat (40) begin tick(); hi_cnt += int'(sclk_o); end
    chk(hi_cnt == 40 && rx_n == 1, "R5 clock idle while cts high", hi_cnt, 40);
    chk(buf_empty_o == 1'b0 && shift_empty_o == 1'b0, "R11 pending byte", shift_empty_o, 0);
    cts_i = 1'b0;
    wait_done();
    chk(rx_n == 2 && rx[1] == 8'h3C, "R5 sent after cts low", rx[1], 8'h3C);

    // R7 R6: blocking mid-frame lets the frame finish, blocks the next
    set_div(1);
    write_byte(8'hC3);
    for (int k = 0; k < 100 && sclk_o; k++) tick();
    write_byte(8'h5A);
    cts_i = 1'b1; tx_en_i = 1'b0;
    wait_rx(3);
    chk(rx_n == 3 && rx[2] == 8'hC3, "R7 started frame completes", rx[2], 8'hC3);
    repeat (30) tick();
    chk(rx_n == 3 && buf_empty_o == 1'b0 && sclk_o, "R5 no start while cts high", rx_n, 3);
    cts_i = 1'b0;
    hi_cnt = 0;
    repeat (30) begin tick(); hi_cnt += int'(sclk_o); end
    chk(rx_n == 3 && hi_cnt == 30, "R6 no start while disabled", hi_cnt, 30);
    tx_en_i = 1'b1;
    wait_done();
    chk(rx_n == 4 && rx[3] == 8'h5A, "R6 sent after enable", rx[3], 8'h5A);

    // R8: back-to-back frames, no idle gap
    set_div(2);
    write_byte(8'h81);
    tick();
    write_byte(8'h7E);
    wait_done();
    chk(gap_ens == half_len(2), "R8 gap between frames", gap_ens, half_len(2));
    chk(rx_n == 6 && rx[4] == 8'h81 && rx[5] == 8'h7E, "R2 back-to-back data", rx[5], 8'h7E);

    // R9: interrupt on buffer transfer
    irq_on_done_i = 1'b0;
    ack();
    chk(irq_o == 1'b0, "R9 ack clears", irq_o, 0);
    write_byte(8'h11);
    tick();
    chk(irq_o == 1'b1, "R9 set on transfer", irq_o, 1);
    ack();
    chk(irq_o == 1'b0, "R9 ack clears after set", irq_o, 0);
    wait_done();
    chk(irq_o == 1'b0, "R9 no set at frame end", irq_o, 0);

    // R10: interrupt on frame completion
    irq_on_done_i = 1'b1;
    write_byte(8'h22);
    tick(); tick();
    chk(irq_o == 1'b0 && shift_empty_o == 1'b0, "R10 not set while shifting", irq_o, 0);
    wait_done();
    chk(irq_o == 1'b1, "R10 set at frame end", irq_o, 1);
    ack();
    irq_on_done_i = 1'b0;

    // R12: new divider value sets the period
    set_div(5);
    write_byte(8'hF0);
    for (int k = 0; k < 200 && sclk_o; k++) tick();
    n0 = 0;
    for (int k = 0; k < 200 && !sclk_o; k++) begin tick(); n0++; end
    chk(n0 == half_len(5), "R12 low phase after new n", n0, half_len(5));
    wait_done();

    // random traffic
    rand_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (shift_empty_o && ($urandom % 3 == 0)) set_div(int'($urandom % 4));
      write_byte(8'($urandom));
      w = int'($urandom % 20);
      for (int k = 0; k < w; k++) begin
        cts_i   = ($urandom % 4 == 0);
        tx_en_i = ($urandom % 5 != 0);
        tick();
      end
      cts_i = 1'b0; tx_en_i = 1'b1;
      for (int k = 0; k < 20000 && !buf_empty_o; k++) tick();
    end
    wait_done();
    rand_en = 1'b0;
    chk(rx_n == sent_n, "R2 frame count", rx_n, sent_n);
    for (int i = 0; i < sent_n && i < 256; i++)
      if (rx[i] !== sent[i]) chk(1'b0, "R2 random byte", rx[i], sent[i]);
    chk(1'b1, "R2 random sequence", 0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule